// File: doc/BRIEF.md
# USB Controller Interrupt Status Register

This block holds the interrupt flags of a controller that can run as a USB host or as a USB device. Single-cycle event strobes come in from the protocol logic of both roles: start-of-frame seen, start-of-frame overdue, bus reset seen, asynchronous schedule advanced, frame index wrapped, and several port state changes. Each strobe sets its own sticky flag. A mode input selects the role. A flag that has meaning only in the other role ignores its strobes while that role is not selected.

Software reaches the block through a small register port with three addresses:
- Status (address 0) holds the flags. Writing 1 to a bit clears that bit.
- Enable (address 1) holds one interrupt enable per implemented flag.
- Command (address 2) holds the doorbell. Software rings it to request an interrupt on the next asynchronous schedule advance.

The interrupt output is registered. It is high whenever any flag is set together with its enable.

Top module: `usbc_irq_status`

## Requirements
- R1: While `rst` is high on a clock edge, all flags, the enable register, the doorbell, `rd_data` and `irq` are 0 after that edge.
- R2: A write to address 0 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R3: When a set strobe and a write-1 clear reach the same flag in the same cycle, the flag is 1 after that edge.
- R4: Bit 7 (frame start) sets on `ev_sof` or on `ev_sof_late`, in either mode.
- R5: Status bit 4 (system error) and bits 1:0 always read 0, and writes to them have no effect.
- R6: Bit 6 (bus reset) sets on `ev_bus_reset` only when `host_mode` is 0.
- R7: Writing 1 to bit 0 of address 2 arms the doorbell, which reads back at address 2 bit 0. An `ev_async_adv` strobe while `host_mode` is 1 and the doorbell is armed does two things: it sets status bit 5 and it disarms the doorbell. Without an armed doorbell, or in device mode, the strobe changes nothing and the doorbell keeps its state.
- R8: Bit 3 (frame list wrap) sets on `ev_frame_roll` only when `host_mode` is 1.
- R9: Bit 2 (port change) responds to different strobes in each mode:
  - With `host_mode` at 1, it sets on `ev_conn_chg`, `ev_en_chg` or `ev_force_resume`.
  - With `host_mode` at 0, it sets on `ev_port_oper`.
  - In each mode, the strobes of the other mode are ignored.
- R10: Address 1 stores only bits 7, 6, 5, 3 and 2 (mask 0xEC); the other bits read 0. `irq` is 1 one edge after some flag and its enable are both 1, and 0 one edge after no such pair remains.
- R11: `rd_data` loads the selected register on the edge where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 selects host role, 0 device role |
| ev_sof | input | 1 | Start of frame seen (strobe) |
| ev_sof_late | input | 1 | Expected start of frame overdue (strobe) |
| ev_bus_reset | input | 1 | Bus reset seen, device entered default state (strobe) |
| ev_async_adv | input | 1 | Asynchronous schedule advanced (strobe) |
| ev_frame_roll | input | 1 | Frame index wrapped to zero (strobe) |
| ev_conn_chg | input | 1 | Host port connect status changed (strobe) |
| ev_en_chg | input | 1 | Host port enable/disable changed (strobe) |
| ev_force_resume | input | 1 | Host port resume forced by J-K transition (strobe) |
| ev_port_oper | input | 1 | Device port entered full/high-speed operation (strobe) |
| rd_en | input | 1 | Register read request |
| wr_en | input | 1 | Register write request |
| addr | input | 2 | Register select: 0 status, 1 enable, 2 command |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A flag stuck at 1, or one that sets in the wrong mode, appears on the read port one edge after the next status read. It also appears on `irq` one edge after the flag changes, if the enable is set. A flag that fails to clear stays visible on every later read. A doorbell that stays armed after it has been consumed sets bit 5 a second time on the next schedule advance. Reading address 2 shows the bad doorbell state directly, one edge after the read.

// File: rtl/usbc_irq_pkg.sv
package usbc_irq_pkg;
  localparam int STS_W   = 8;
  localparam int B_SOF   = 7;
  localparam int B_URST  = 6;
  localparam int B_AADV  = 5;
  localparam int B_SERR  = 4;
  localparam int B_FROLL = 3;
  localparam int B_PCHG  = 2;
  localparam logic [STS_W-1:0] IMPL_MASK = 8'hEC;

  typedef enum logic [1:0] {
    A_STATUS = 2'd0,
    A_ENABLE = 2'd1,
    A_CMD    = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic sof;
    logic sof_late;
    logic bus_reset;
    logic async_adv;
    logic frame_roll;
    logic conn_chg;
    logic en_chg;
    logic force_resume;
    logic port_oper;
  } evt_t;
endpackage

// File: rtl/usbc_irq_setgen.sv
module usbc_irq_setgen
  import usbc_irq_pkg::*;
#(
  parameter int W = STS_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         host_mode,
  input  evt_t         evt,
  input  logic         ring,
  output logic [W-1:0] set_vec,
  output logic         bell_q
);
  logic consume;
  logic host_pc, dev_pc;

  // doorbell is consumed only by a host-mode advance while armed
  assign consume = host_mode & evt.async_adv & bell_q;

  always_ff @(posedge clk) begin
    if (rst) bell_q <= 1'b0;
    else     bell_q <= (bell_q & ~consume) | ring;
  end

  assign host_pc = host_mode & (evt.conn_chg | evt.en_chg | evt.force_resume);
  assign dev_pc  = ~host_mode & evt.port_oper;

  always_comb begin
    set_vec          = '0;
    set_vec[B_SOF]   = evt.sof | evt.sof_late;
    set_vec[B_URST]  = ~host_mode & evt.bus_reset;
    set_vec[B_AADV]  = consume;
    set_vec[B_SERR]  = 1'b0;
    set_vec[B_FROLL] = host_mode & evt.frame_roll;
    set_vec[B_PCHG]  = host_pc | dev_pc;
  end
endmodule

// File: rtl/usbc_irq_flags.sv
module usbc_irq_flags #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    IMPL = 8'hEC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst)             flags_q[i] <= 1'b0;
        else if (set_vec[i]) flags_q[i] <= 1'b1;  // set beats clear
        else if (clr_vec[i]) flags_q[i] <= 1'b0;
      end
    end else begin : g_zero
      assign flags_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usbc_irq_regif.sv
module usbc_irq_regif
  import usbc_irq_pkg::*;
#(
  parameter int           W    = STS_W,
  parameter logic [W-1:0] IMPL = IMPL_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] flags,
  input  logic         bell,
  output logic [W-1:0] clr_vec,
  output logic         ring,
  output logic [W-1:0] en_q,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  reg_addr_e    sel;
  logic [W-1:0] rd_mux;

  assign sel     = reg_addr_e'(addr);
  assign clr_vec = (wr_en && sel == A_STATUS) ? (wr_data & IMPL) : '0;
  assign ring    = wr_en && sel == A_CMD && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst)                           en_q <= '0;
    else if (wr_en && sel == A_ENABLE) en_q <= wr_data & IMPL;
  end

  always_comb begin
    case (sel)
      A_STATUS: rd_mux = flags;
      A_ENABLE: rd_mux = en_q;
      A_CMD:    rd_mux = {{(W-1){1'b0}}, bell};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      irq <= |(flags & en_q);
    end
  end
endmodule

// File: rtl/usbc_irq_status.sv
module usbc_irq_status
  import usbc_irq_pkg::*;
#(
  parameter int DATA_W = STS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_mode,
  input  logic              ev_sof,
  input  logic              ev_sof_late,
  input  logic              ev_bus_reset,
  input  logic              ev_async_adv,
  input  logic              ev_frame_roll,
  input  logic              ev_conn_chg,
  input  logic              ev_en_chg,
  input  logic              ev_force_resume,
  input  logic              ev_port_oper,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam logic [DATA_W-1:0] IMPL = IMPL_MASK;

  evt_t              evt;
  logic [DATA_W-1:0] set_vec, clr_vec, status_q, enable_q;
  logic              ring, bell_q;

  assign evt = '{sof: ev_sof, sof_late: ev_sof_late, bus_reset: ev_bus_reset,
                 async_adv: ev_async_adv, frame_roll: ev_frame_roll,
                 conn_chg: ev_conn_chg, en_chg: ev_en_chg,
                 force_resume: ev_force_resume, port_oper: ev_port_oper};

  usbc_irq_setgen #(.W(DATA_W)) u_setgen (
    .clk(clk), .rst(rst), .host_mode(host_mode), .evt(evt),
    .ring(ring), .set_vec(set_vec), .bell_q(bell_q)
  );

  usbc_irq_flags #(.W(DATA_W), .IMPL(IMPL)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .flags_q(status_q)
  );

  usbc_irq_regif #(.W(DATA_W), .IMPL(IMPL)) u_regif (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .flags(status_q), .bell(bell_q), .clr_vec(clr_vec),
    .ring(ring), .en_q(enable_q), .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/usbc_irq_chk.sv
module usbc_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_mode,
  input logic       ev_sof,
  input logic       ev_sof_late,
  input logic       rd_en,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [7:0] flags,
  input logic [7:0] en,
  input logic       irq
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (flags == 8'h00 && en == 8'h00 && !irq && rd_data == 8'h00));

  assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
    (!host_mode && wr_en && addr == 2'd0 && wr_data[3]) |=> !flags[3]);

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_sof && wr_en && addr == 2'd0 && wr_data[7]) |=> flags[7]);

  assert_late_sof_R4: assert property (@(posedge clk) disable iff (rst)
    ev_sof_late |=> flags[7]);

  assert_serr_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd0) |=> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));

  assert_urst_host_R6: assert property (@(posedge clk) disable iff (rst)
    (host_mode && !flags[6]) |=> !flags[6]);

  assert_froll_dev_R8: assert property (@(posedge clk) disable iff (rst)
    (!host_mode && !flags[3]) |=> !flags[3]);

  assert_irq_hi_R10: assert property (@(posedge clk) disable iff (rst)
    ((flags & en) != 8'h00) |=> irq);

  assert_irq_lo_R10: assert property (@(posedge clk) disable iff (rst)
    ((flags & en) == 8'h00) |=> !irq);

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind usbc_irq_status usbc_irq_chk u_chk (
  .clk(clk), .rst(rst), .host_mode(host_mode), .ev_sof(ev_sof),
  .ev_sof_late(ev_sof_late), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .flags(status_q), .en(enable_q),
  .irq(irq)
);

// File: tb/sim_usbc_irq_status.sv
module sim_usbc_irq_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_mode = 1'b0;
  logic [8:0] ev = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;
  int checks = 0, errors = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  // ev: [8]sof [7]sof_late [6]bus_reset [5]async_adv [4]frame_roll
  //     [3]conn_chg [2]en_chg [1]force_resume [0]port_oper
  usbc_irq_status u0 (
    .clk(clk), .rst(rst), .host_mode(host_mode),
    .ev_sof(ev[8]), .ev_sof_late(ev[7]), .ev_bus_reset(ev[6]),
    .ev_async_adv(ev[5]), .ev_frame_roll(ev[4]), .ev_conn_chg(ev[3]),
    .ev_en_chg(ev[2]), .ev_force_resume(ev[1]), .ev_port_oper(ev[0]),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  // {host_mode, events[8:0], expected status}
  localparam logic [17:0] VEC [16] = '{
    {1'b1, 9'b100000000, 8'h80},  // R4 sof host
    {1'b0, 9'b010000000, 8'h80},  // R4 late sof device
    {1'b0, 9'b001000000, 8'h40},  // R6 reset device
    {1'b1, 9'b001000000, 8'h00},  // R6 reset ignored in host
    {1'b1, 9'b000010000, 8'h08},  // R8 rollover host
    {1'b0, 9'b000010000, 8'h00},  // R8 rollover ignored in device
    {1'b1, 9'b000001000, 8'h04},  // R9 connect
    {1'b1, 9'b000000100, 8'h04},  // R9 enable change
    {1'b1, 9'b000000010, 8'h04},  // R9 forced resume
    {1'b1, 9'b000000001, 8'h00},  // R9 device strobe ignored in host
    {1'b0, 9'b000000001, 8'h04},  // R9 device operational
    {1'b0, 9'b000001110, 8'h00},  // R9 host strobes ignored in device
    {1'b1, 9'b000100000, 8'h00},  // R7 advance without doorbell
    {1'b1, 9'b100011000, 8'h8C},  // R4 R8 R9 mixed
    {1'b0, 9'b111111111, 8'hC4},  // all strobes device
    {1'b1, 9'b111111111, 8'h8C}   // all strobes host
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1; tick(); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1; tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [8:0] e);
    ev = e; tick(); ev = '0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 1'b0; tick();
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd(2'd0, got); check("R1 status", got, 8'h00);
    rd(2'd1, got); check("R1 enable", got, 8'h00);
    rd(2'd2, got); check("R1 doorbell", got, 8'h00);

    for (int i = 0; i < 16; i++) begin
      host_mode = VEC[i][17];
      pulse(VEC[i][16:8]);
      rd(2'd0, got);
      check($sformatf("vector %0d", i), got, VEC[i][7:0]);
      wr(2'd0, 8'hFF);
      rd(2'd0, got);
      check($sformatf("R2 clear all after vector %0d", i), got, 8'h00);
    end

    // R2: write 0 keeps, write 1 clears
    host_mode = 1'b1;
    pulse(9'b000010000);
    wr(2'd0, 8'hF7);
    rd(2'd0, got); check("R2 zero bit keeps", got, 8'h08);
    wr(2'd0, 8'h08);
    rd(2'd0, got); check("R2 one bit clears", got, 8'h00);

    // R3: set and clear same cycle
    ev = 9'b100000000; addr = 2'd0; wr_data = 8'h80; wr_en = 1'b1;
    tick(); ev = '0; wr_en = 1'b0;
    rd(2'd0, got); check("R3 set wins", got, 8'h80);
    wr(2'd0, 8'hFF);

    // R5: writes to unimplemented bits do nothing
    wr(2'd0, 8'h13);
    rd(2'd0, got); check("R5 status reserved", got, 8'h00);

    // R10: enable mask readback
    wr(2'd1, 8'hFF);
    rd(2'd1, got); check("R10 enable mask", got, 8'hEC);

    // R7: doorbell in host mode
    host_mode = 1'b1;
    wr(2'd2, 8'h01);
    rd(2'd2, got); check("R7 doorbell armed", got, 8'h01);
    pulse(9'b000100000);
    rd(2'd0, got); check("R7 advance sets flag", got, 8'h20);
    rd(2'd2, got); check("R7 doorbell disarmed", got, 8'h00);
    wr(2'd0, 8'hFF);
    pulse(9'b000100000);
    rd(2'd0, got); check("R7 second advance ignored", got, 8'h00);
    // R7: device mode leaves doorbell armed
    host_mode = 1'b0;
    wr(2'd2, 8'h01);
    pulse(9'b000100000);
    rd(2'd0, got); check("R7 device advance ignored", got, 8'h00);
    rd(2'd2, got); check("R7 doorbell kept", got, 8'h01);
    host_mode = 1'b1;
    pulse(9'b000100000);
    rd(2'd0, got); check("R7 host advance after switch", got, 8'h20);
    wr(2'd0, 8'hFF);

    // R10: irq timing
    wr(2'd1, 8'h04);
    tick();
    check("R10 irq idle", {7'b0, irq}, 8'h00);
    pulse(9'b000001000);
    check("R10 irq not yet", {7'b0, irq}, 8'h00);
    tick();
    check("R10 irq raised", {7'b0, irq}, 8'h01);
    pulse(9'b000010000);  // rollover with its enable off
    wr(2'd0, 8'h04);
    check("R10 irq one edge after clear", {7'b0, irq}, 8'h01);
    tick();
    check("R10 irq dropped, unenabled flag set", {7'b0, irq}, 8'h00);
    wr(2'd0, 8'hFF);

    // R11: read data holds without rd_en
    rd(2'd0, got);
    pulse(9'b100000000);
    tick();
    check("R11 rd_data held", rd_data, 8'h00);
    rd(2'd0, got); check("R11 fresh read", got, 8'h80);

    // R1: mid-run reset
    wr(2'd2, 8'h01);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 rd_data after reset", rd_data, 8'h00);
    rd(2'd0, got); check("R1 status after reset", got, 8'h00);
    rd(2'd1, got); check("R1 enable after reset", got, 8'h00);
    rd(2'd2, got); check("R1 doorbell after reset", got, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule